// File: doc/BRIEF.md
# Legacy Memory Region Decoder

This block sits between a processor-side request port and the memories of a system that runs real-mode firmware in a 1 MB address window carried on a 32-bit address bus. For every byte, word or dword request it picks one target: the option-ROM window starting at 0xC0000, the video-memory window at 0xA0000–0xBFFFF, a tiny built-in identification ROM in the last eleven bytes of the 1 MB space, or plain system RAM. It returns the chosen target, the offset inside that target, the byte-lane enables and a write enable. For reads that it can answer alone, it also supplies the read data itself. These are the identification bytes, and video reads while video emulation is on.

The top of the option-ROM window is set by an input. Addresses between that limit and 0xD0000 form a dead gap. A request in the gap is flagged and sent to RAM offset 0. A request that reaches the RAM stage at or past the configured RAM size sets a sticky halt flag, and it too lands on RAM offset 0. Each result is registered and appears one clock after the request strobe.

Top module: `lmd_top`

## Requirements
- R1: A request with 0xC0000 <= address <= `rom_limit` gives target code 1 (option ROM) with offset address − 0xC0000; this check comes first. `rom_limit` is assumed to be at least 0xBFFFF.
- R2: A request with `rom_limit` < address < 0xD0000 gives target code 0 (RAM), offset 0 and `rsp_gap` = 1; `rsp_gap` is 0 for every other request.
- R3: A request in 0xA0000–0xBFFFF gives target code 2 (video) with offset address − 0xA0000. While `vga_emulate` is 0, writes pass with `rsp_wr_en` = 1.
- R4: While `vga_emulate` is 1, a video-window request keeps target code 2, drives `rsp_wr_en` = 0 and `rsp_local` = 1, and returns `rsp_rdata` = 0.
- R5: Addresses 0xFFFF5..0xFFFFC read as the ASCII bytes of "08/14/99" in order, one per address. Address 0xFFFFD reads 0x00. The target code is 3 and `rsp_local` = 1.
- R6: Address 0xFFFFE reads model byte 0xFC and 0xFFFFF reads submodel byte 0x00. Lanes that fall past 0xFFFFF read 0.
- R7: Any other address below `ram_size` gives target code 0 with offset equal to the address. One at or above `ram_size` gives target 0, offset 0, and sets `halt`, which stays 1 until reset.
- R8: `req_size` encodes 0 = byte, 1 = word, 2 = dword (3 is treated as dword). `rsp_be` is 0x1, 0x3 or 0xF accordingly. Data is little-endian: lane k (bits 8k+7..8k) is the byte at offset + k, both in `rsp_rdata` and `rsp_wdata`.
- R9: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1, and all response fields belong to that request.
- R10: Writes to the identification bytes are discarded (`rsp_wr_en` = 0). `rsp_rdata` is 0 whenever `rsp_local` = 0.
- R11: After reset `rsp_valid`, `halt`, `rsp_gap` and `rsp_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rom_limit | input | 32 | Last address of the option-ROM window |
| ram_size | input | 32 | Number of RAM bytes |
| vga_emulate | input | 1 | Suppress video-window accesses |
| rsp_valid | output | 1 | Decode result valid |
| rsp_target | output | 2 | 0 RAM, 1 option ROM, 2 video, 3 identification ROM |
| rsp_offset | output | 32 | Offset within the target |
| rsp_be | output | 4 | Byte-lane enables |
| rsp_wr_en | output | 1 | Write to be performed on the target |
| rsp_wdata | output | 32 | Write data passed through |
| rsp_local | output | 1 | Read data is supplied by this block |
| rsp_rdata | output | 32 | Locally supplied read data |
| rsp_gap | output | 1 | Request fell in the dead gap |
| halt | output | 1 | Sticky out-of-range flag |

## Verification
The bench moves the option-ROM limit and probes both sides of it. A decoder with an off-by-one compare would send the last ROM byte into the gap, or let the first gap byte reach the ROM. It reads the identification area with wide accesses that run past the top of the 1 MB space. A wrong lane order or a missing clamp would show up as swapped bytes or as stray data in the upper lanes. It toggles video emulation between writes and reads, so a leaking write enable or non-zero read data is caught. Finally it drives RAM accesses after an overrun to confirm the halt flag is sticky and that in-range offsets are unaffected.

// File: rtl/lmd_pkg.sv
// Shared constants and types of the legacy memory region decoder.
package lmd_pkg;

    typedef enum logic [1:0] {
        TGT_RAM    = 2'd0,
        TGT_OPTROM = 2'd1,
        TGT_VIDEO  = 2'd2,
        TGT_IDROM  = 2'd3
    } lmd_target_e;

    // Fixed region boundaries of the real-mode map
    localparam logic [31:0] OPTROM_BASE = 32'h000C_0000;
    localparam logic [31:0] GAP_END     = 32'h000D_0000;
    localparam logic [31:0] VIDEO_BASE  = 32'h000A_0000;
    localparam logic [31:0] VIDEO_LAST  = 32'h000B_FFFF;
    localparam logic [31:0] ID_BASE     = 32'h000F_FFF5;
    localparam logic [31:0] ID_LAST     = 32'h000F_FFFF;

    // Identification content: 8 date characters, terminator, model, submodel
    localparam logic [63:0] DATE_TEXT   = "08/14/99";
    localparam int          DATE_LEN    = 8;

endpackage

// File: rtl/lmd_region_class.sv
// Region classifier: pure combinational decode of one address into a
// target, an offset and the gap/overrun/suppress qualifiers.
// Assumes rom_limit >= VIDEO_LAST so the gap never covers the video window.
module lmd_region_class
    import lmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] rom_limit,
    input  logic [ADDR_W-1:0] ram_size,
    input  logic              vga_emulate,
    output lmd_target_e       target,
    output logic [ADDR_W-1:0] offset,
    output logic              in_gap,
    output logic              overrun,
    output logic              suppress
);

    localparam logic [ADDR_W-1:0] OR_BASE = ADDR_W'(OPTROM_BASE);
    localparam logic [ADDR_W-1:0] G_END   = ADDR_W'(GAP_END);
    localparam logic [ADDR_W-1:0] V_BASE  = ADDR_W'(VIDEO_BASE);
    localparam logic [ADDR_W-1:0] V_LAST  = ADDR_W'(VIDEO_LAST);
    localparam logic [ADDR_W-1:0] I_BASE  = ADDR_W'(ID_BASE);
    localparam logic [ADDR_W-1:0] I_LAST  = ADDR_W'(ID_LAST);

    // Priority chain: option ROM, gap, video, identification, RAM
    always_comb begin
        target   = TGT_RAM;
        offset   = '0;
        in_gap   = 1'b0;
        overrun  = 1'b0;
        suppress = 1'b0;
        if (addr >= OR_BASE && addr <= rom_limit) begin
            target = TGT_OPTROM;
            offset = addr - OR_BASE;
        end else if (addr > rom_limit && addr < G_END) begin
            in_gap = 1'b1;
        end else if (addr >= V_BASE && addr <= V_LAST) begin
            target   = TGT_VIDEO;
            offset   = addr - V_BASE;
            suppress = vga_emulate;
        end else if (addr >= I_BASE && addr <= I_LAST) begin
            target = TGT_IDROM;
            offset = addr - I_BASE;
        end else if (addr >= ram_size) begin
            overrun = 1'b1;
        end else begin
            offset = addr;
        end
    end

endmodule

// File: rtl/lmd_lane_mask.sv
// Lane-enable generator: turns the size code into one enable per byte lane.
// Assumes LANES is 4 (dword bus); size code 3 enables every lane.
module lmd_lane_mask #(
    parameter int LANES = 4
) (
    input  logic [1:0]       size,
    output logic [LANES-1:0] be
);

    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] n_bytes;

    // Number of bytes the access covers
    always_comb begin
        case (size)
            2'd0:    n_bytes = CNT_W'(1);
            2'd1:    n_bytes = CNT_W'(2);
            default: n_bytes = CNT_W'(LANES);
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign be[k] = (CNT_W'(k) < n_bytes);
    end

endmodule

// File: rtl/lmd_id_rom.sv
// Identification ROM: returns the built-in date, model and submodel bytes
// for each enabled lane, little-endian from the request address upward.
// Lanes outside the identification range read zero.
module lmd_id_rom
    import lmd_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         LANES    = 4,
    parameter logic [7:0] MODEL    = 8'hFC,
    parameter logic [7:0] SUBMODEL = 8'h00
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LANES-1:0]   be,
    output logic [8*LANES-1:0] data
);

    localparam logic [ADDR_W-1:0] I_BASE = ADDR_W'(ID_BASE);
    localparam logic [ADDR_W-1:0] I_LAST = ADDR_W'(ID_LAST);

    function automatic logic [7:0] id_byte(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] idx;
        logic [7:0]        res;
        idx = a - I_BASE;
        res = 8'h00;
        if (a >= I_BASE && a <= I_LAST) begin
            if (idx < ADDR_W'(DATE_LEN))
                res = DATE_TEXT[(DATE_LEN - 1 - int'(idx[3:0])) * 8 +: 8];
            else if (idx == ADDR_W'(DATE_LEN + 1))
                res = MODEL;
            else if (idx == ADDR_W'(DATE_LEN + 2))
                res = SUBMODEL;
        end
        return res;
    endfunction

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Byte for lane k comes from address + k
        always_comb begin
            data[8*k +: 8] = be[k] ? id_byte(addr + ADDR_W'(k)) : 8'h00;
        end
    end

endmodule

// File: rtl/lmd_top.sv
// Legacy memory region decoder top: classifies each request, derives lane
// enables and local read data, and registers the result one cycle after the
// request strobe. Holds the sticky halt flag. Synchronous active-low reset.
module lmd_top
    import lmd_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         DATA_W   = 32,
    parameter logic [7:0] MODEL    = 8'hFC,
    parameter logic [7:0] SUBMODEL = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [ADDR_W-1:0]   rom_limit,
    input  logic [ADDR_W-1:0]   ram_size,
    input  logic                vga_emulate,
    output logic                rsp_valid,
    output logic [1:0]          rsp_target,
    output logic [ADDR_W-1:0]   rsp_offset,
    output logic [DATA_W/8-1:0] rsp_be,
    output logic                rsp_wr_en,
    output logic [DATA_W-1:0]   rsp_wdata,
    output logic                rsp_local,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_gap,
    output logic                halt
);

    localparam int LANES = DATA_W / 8;

    lmd_target_e         c_target;
    logic [ADDR_W-1:0]   c_offset;
    logic                c_gap;
    logic                c_overrun;
    logic                c_suppress;
    logic [LANES-1:0]    c_be;
    logic [DATA_W-1:0]   c_id_data;
    logic                c_local;
    logic                c_wr_en;
    logic [DATA_W-1:0]   c_rdata;

    lmd_region_class #(.ADDR_W(ADDR_W)) u_class (
        .addr        (req_addr),
        .rom_limit   (rom_limit),
        .ram_size    (ram_size),
        .vga_emulate (vga_emulate),
        .target      (c_target),
        .offset      (c_offset),
        .in_gap      (c_gap),
        .overrun     (c_overrun),
        .suppress    (c_suppress)
    );

    lmd_lane_mask #(.LANES(LANES)) u_lanes (
        .size (req_size),
        .be   (c_be)
    );

    lmd_id_rom #(
        .ADDR_W   (ADDR_W),
        .LANES    (LANES),
        .MODEL    (MODEL),
        .SUBMODEL (SUBMODEL)
    ) u_id (
        .addr (req_addr),
        .be   (c_be),
        .data (c_id_data)
    );

    // Local read data and write permission for the current request
    always_comb begin
        c_local = c_suppress || (c_target == TGT_IDROM);
        c_wr_en = req_write && !c_local;
        c_rdata = (c_target == TGT_IDROM) ? c_id_data : '0;
    end

    // Response register, loaded on each request strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_target <= 2'd0;
            rsp_offset <= '0;
            rsp_be     <= '0;
            rsp_wr_en  <= 1'b0;
            rsp_wdata  <= '0;
            rsp_local  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_gap    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_target <= c_target;
                rsp_offset <= c_offset;
                rsp_be     <= c_be;
                rsp_wr_en  <= c_wr_en;
                rsp_wdata  <= req_wdata;
                rsp_local  <= c_local;
                rsp_rdata  <= c_rdata;
                rsp_gap    <= c_gap;
            end
        end
    end

    // Sticky halt flag, set by any out-of-range RAM request
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt <= 1'b0;
        else if (req_valid && c_overrun)
            halt <= 1'b1;
    end

endmodule

// File: rtl/lmd_checker.sv
// Property checker for the legacy memory region decoder, bound to lmd_top.
module lmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        vga_emulate,
    input logic        rsp_valid,
    input logic [1:0]  rsp_target,
    input logic [31:0] rsp_offset,
    input logic [3:0]  rsp_be,
    input logic        rsp_wr_en,
    input logic        rsp_local,
    input logic [31:0] rsp_rdata,
    input logic        rsp_gap,
    input logic        halt
);

    // R9: response strobe follows the request strobe by one cycle
    a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7: halt never clears without reset
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R2: gap results land on RAM offset 0
    a_r2_gap_to_ram0: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_gap |-> (rsp_target == 2'd0 && rsp_offset == 32'd0));

    // R4: emulated video accesses are blocked and read zero
    a_r4_video_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vga_emulate && req_addr >= 32'h000A_0000 && req_addr <= 32'h000B_FFFF)
        |=> (rsp_target == 2'd2 && !rsp_wr_en && rsp_local && rsp_rdata == 32'd0));

    // R10: identification bytes are never written; non-local data is zero
    a_r10_id_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_target == 2'd3) |-> (!rsp_wr_en && rsp_local));
    a_r10_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_local |-> (rsp_rdata == 32'd0));

    // R8: lane enables are one of the three legal patterns
    a_r8_be_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_be == 4'h1 || rsp_be == 4'h3 || rsp_be == 4'hF));

endmodule

bind lmd_top lmd_checker u_lmd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .vga_emulate (vga_emulate),
    .rsp_valid   (rsp_valid),
    .rsp_target  (rsp_target),
    .rsp_offset  (rsp_offset),
    .rsp_be      (rsp_be),
    .rsp_wr_en   (rsp_wr_en),
    .rsp_local   (rsp_local),
    .rsp_rdata   (rsp_rdata),
    .rsp_gap     (rsp_gap),
    .halt        (halt)
);

// File: tb/tb_lmd_top.sv
// Directed bench for lmd_top: one task per scenario, each checking itself.
module tb_lmd_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [1:0]  req_size;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [31:0] rom_limit;
    logic [31:0] ram_size;
    logic        vga_emulate;
    logic        rsp_valid;
    logic [1:0]  rsp_target;
    logic [31:0] rsp_offset;
    logic [3:0]  rsp_be;
    logic        rsp_wr_en;
    logic [31:0] rsp_wdata;
    logic        rsp_local;
    logic [31:0] rsp_rdata;
    logic        rsp_gap;
    logic        halt;

    int checks = 0;
    int errors = 0;
    logic seen_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmd_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rom_limit(rom_limit), .ram_size(ram_size), .vga_emulate(vga_emulate),
        .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_offset(rsp_offset),
        .rsp_be(rsp_be), .rsp_wr_en(rsp_wr_en), .rsp_wdata(rsp_wdata),
        .rsp_local(rsp_local), .rsp_rdata(rsp_rdata), .rsp_gap(rsp_gap), .halt(halt)
    );

    task automatic check1(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and sample the response one cycle later
    task automatic access(input logic [31:0] a, input logic [1:0] sz,
                          input logic wr, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        seen_valid = rsp_valid;
    endtask

    // Compare the full response of the last access
    task automatic expect_rsp(input string tag, input logic [1:0] tgt, input logic [31:0] off,
                              input logic [3:0] be, input logic wen, input logic loc,
                              input logic [31:0] rd, input logic gap);
        check1({tag, " valid"}, {31'd0, seen_valid}, 32'd1);
        check1({tag, " resp"},
               {rsp_target, rsp_be, rsp_wr_en, rsp_local, rsp_gap, 23'd0},
               {tgt, be, wen, loc, gap, 23'd0});
        check1({tag, " offset"}, rsp_offset, off);
        check1({tag, " rdata"}, rsp_rdata, rd);
    endtask

    task automatic t_reset;
        // R11: idle state after reset
        check1("R11 reset state", {28'd0, rsp_valid, halt, rsp_gap, rsp_wr_en}, 32'd0);
        @(negedge clk);
        check1("R9 idle no valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_optrom;
        rom_limit = 32'h000C_7FFF;
        access(32'h000C_1234, 2'd2, 1'b0, 32'd0);
        expect_rsp("R1 optrom mid", 2'd1, 32'h1234, 4'hF, 1'b0, 1'b0, 32'd0, 1'b0);
        access(32'h000C_7FFF, 2'd0, 1'b1, 32'hA5);
        expect_rsp("R1 optrom last", 2'd1, 32'h7FFF, 4'h1, 1'b1, 1'b0, 32'd0, 1'b0);
        access(32'h000C_0000, 2'd1, 1'b0, 32'd0);
        expect_rsp("R1 optrom base", 2'd1, 32'h0, 4'h3, 1'b0, 1'b0, 32'd0, 1'b0);
    endtask

    task automatic t_gap;
        access(32'h000C_8000, 2'd0, 1'b0, 32'd0);
        expect_rsp("R2 gap first", 2'd0, 32'h0, 4'h1, 1'b0, 1'b0, 32'd0, 1'b1);
        access(32'h000C_FFFF, 2'd0, 1'b1, 32'h11);
        expect_rsp("R2 gap last", 2'd0, 32'h0, 4'h1, 1'b1, 1'b0, 32'd0, 1'b1);
        access(32'h000D_0000, 2'd0, 1'b0, 32'd0);
        expect_rsp("R7 after gap ram", 2'd0, 32'h000D_0000, 4'h1, 1'b0, 1'b0, 32'd0, 1'b0);
        // R1: moving the limit shrinks the gap
        rom_limit = 32'h000C_FFFF;
        access(32'h000C_8000, 2'd0, 1'b0, 32'd0);
        expect_rsp("R1 raised limit", 2'd1, 32'h8000, 4'h1, 1'b0, 1'b0, 32'd0, 1'b0);
        rom_limit = 32'h000C_7FFF;
    endtask

    task automatic t_video;
        vga_emulate = 1'b0;
        access(32'h000A_0000, 2'd1, 1'b1, 32'h0000_BEEF);
        expect_rsp("R3 video base wr", 2'd2, 32'h0, 4'h3, 1'b1, 1'b0, 32'd0, 1'b0);
        check1("R8 wdata lanes", rsp_wdata, 32'h0000_BEEF);
        access(32'h000B_FFFF, 2'd0, 1'b0, 32'd0);
        expect_rsp("R3 video last", 2'd2, 32'h1_FFFF, 4'h1, 1'b0, 1'b0, 32'd0, 1'b0);
        vga_emulate = 1'b1;
        access(32'h000A_0010, 2'd2, 1'b0, 32'd0);
        expect_rsp("R4 emu read", 2'd2, 32'h10, 4'hF, 1'b0, 1'b1, 32'd0, 1'b0);
        access(32'h000B_0000, 2'd2, 1'b1, 32'hDEAD_BEEF);
        expect_rsp("R4 emu write", 2'd2, 32'h1_0000, 4'hF, 1'b0, 1'b1, 32'd0, 1'b0);
        access(32'h000C_0004, 2'd0, 1'b1, 32'h22);
        expect_rsp("R4 optrom unaffected", 2'd1, 32'h4, 4'h1, 1'b1, 1'b0, 32'd0, 1'b0);
        vga_emulate = 1'b0;
    endtask

    task automatic t_idrom;
        access(32'h000F_FFF5, 2'd0, 1'b0, 32'd0);
        expect_rsp("R5 date first", 2'd3, 32'h0, 4'h1, 1'b0, 1'b1, 32'h30, 1'b0);
        access(32'h000F_FFF5, 2'd2, 1'b0, 32'd0);
        expect_rsp("R5 R8 date dword", 2'd3, 32'h0, 4'hF, 1'b0, 1'b1, 32'h312F_3830, 1'b0);
        access(32'h000F_FFF9, 2'd2, 1'b0, 32'd0);
        expect_rsp("R5 date tail", 2'd3, 32'h4, 4'hF, 1'b0, 1'b1, 32'h3939_2F34, 1'b0);
        access(32'h000F_FFFC, 2'd2, 1'b0, 32'd0);
        expect_rsp("R5 R6 term model", 2'd3, 32'h7, 4'hF, 1'b0, 1'b1, 32'h00FC_0039, 1'b0);
        access(32'h000F_FFFE, 2'd1, 1'b0, 32'd0);
        expect_rsp("R6 model word", 2'd3, 32'h9, 4'h3, 1'b0, 1'b1, 32'h0000_00FC, 1'b0);
        access(32'h000F_FFFF, 2'd3, 1'b0, 32'd0);
        expect_rsp("R6 R8 submodel past top", 2'd3, 32'hA, 4'hF, 1'b0, 1'b1, 32'h0, 1'b0);
        access(32'h000F_FFFE, 2'd0, 1'b1, 32'h55);
        expect_rsp("R10 id write dropped", 2'd3, 32'h9, 4'h1, 1'b0, 1'b1, 32'h0000_00FC, 1'b0);
        access(32'h000F_FFF4, 2'd0, 1'b0, 32'd0);
        expect_rsp("R7 below id ram", 2'd0, 32'h000F_FFF4, 4'h1, 1'b0, 1'b0, 32'd0, 1'b0);
    endtask

    task automatic t_ram_halt;
        ram_size = 32'h0008_0000;
        access(32'h0007_FFFF, 2'd0, 1'b1, 32'h77);
        expect_rsp("R7 ram last", 2'd0, 32'h0007_FFFF, 4'h1, 1'b1, 1'b0, 32'd0, 1'b0);
        check1("R7 no halt yet", {31'd0, halt}, 32'd0);
        access(32'h0008_0000, 2'd2, 1'b0, 32'd0);
        expect_rsp("R7 overrun", 2'd0, 32'h0, 4'hF, 1'b0, 1'b0, 32'd0, 1'b0);
        check1("R7 halt set", {31'd0, halt}, 32'd1);
        access(32'h0000_0100, 2'd1, 1'b0, 32'd0);
        expect_rsp("R7 ram after halt", 2'd0, 32'h100, 4'h3, 1'b0, 1'b0, 32'd0, 1'b0);
        check1("R7 halt sticky", {31'd0, halt}, 32'd1);
        repeat (3) @(negedge clk);
        check1("R9 valid drops", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_addr = '0; req_wdata = '0; rom_limit = 32'h000C_7FFF;
        ram_size = 32'h0010_0000; vga_emulate = 1'b0; seen_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_optrom();
        t_gap();
        t_video();
        t_idrom();
        t_ram_halt();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule